// File: doc/BRIEF.md
# Flash Command and Write Controller

This block is the control core of a 16-bit NOR-style flash device, written as a synthesizable model with a small register-based array standing in for the cells. A bus in the style of an asynchronous SRAM (active-low chip select, output enable and write strobe, plus address and data) is sampled on the system clock. Each rising edge of the write strobe while the chip is selected counts as one command cycle. The command decoder uses these cycles to start word writes, block erases and lock-bit changes. It can also suspend and resume them, and it selects what a read cycle returns.

The duration of each internal operation is a cycle count set by a parameter. The ready/busy output and the status register report progress. An active-low power-down input resets the automation, and two supply-good inputs (program voltage and core voltage) prevent any change to the array. Per-block lock bits reject writes and erases aimed at protected blocks. The default array is a scaled stand-in (16 blocks of 16 words). A full-size device uses BLK_W=4 and WOFF_W=15, so address bits [18:15] pick the block.

Top module: `flash_ctl`

## Requirements
- R1: `data_oe_o` is 1 only while `ce_ni`=0, `oe_ni`=0 and `pwd_ni`=1. A read then returns one of three sources. In array mode it returns the stored word. In status mode it returns {8'h00, status}. In identifier mode it returns MFR_ID at word offset 0, DEV_ID at offset 1, and the addressed block's lock bit in bit 0 at offset 2.
- R2: Commands take the low data byte of a command cycle. The one-cycle commands are 0xFF (array mode), 0x90 (identifier mode), 0x70 (status mode), 0x50 (clear errors), 0xB0 (suspend) and 0xD0 (resume). An undefined opcode changes nothing.
- R3: A word write is 0x40 followed by a cycle carrying address and data. It stores old AND data, and `ready_o` stays low for exactly WRITE_CYC clock cycles.
- R4: A block erase is 0x20 followed by 0xD0, and it sets every word of the addressed block to 0xFFFF. Any other second byte sets status bits 5 and 4 and erases nothing.
- R5: 0x60 then 0x01 sets a block's lock bit, and 0x60 then 0xD0 clears it. A write to a locked block sets status bits 4 and 1, and an erase of one sets bits 5 and 1. Neither changes the array.
- R6: If `vpp_ok_i` is 0 when an operation starts or ends, the operation changes no memory and sets its error bit plus bit 3. If `vcc_ok_i` is 0, the operation changes no memory and sets only its error bit.
- R7: The status byte is {ready, erase-suspended, erase-error, write-error, vpp-low, write-suspended, lock-error, 0}. Error bits stay set until 0x50.
- R8: 0xB0 during a running word write halts it and sets status bit 2. The array then reads its old contents. 0xD0 resumes the write, which then completes.
- R9: 0xB0 during a running erase halts it and sets status bit 6. While the erase is halted, the array can be read and a word write to another block can run. A write to the halted block is rejected with bit 4. 0xD0 resumes the erase.
- R10: `ready_o` is 0 only while an operation is actually running. It is 1 when idle, when an operation is suspended, and during power-down.
- R11: `pwd_ni`=0 aborts any operation without changing memory, ignores bus writes and clears the error bits. The device returns to array mode.
- R12: The block number is the top BLK_W address bits. Erase and lock act only on the addressed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwd_ni | input | 1 | Active-low reset / deep power-down |
| vpp_ok_i | input | 1 | Program voltage above lockout |
| vcc_ok_i | input | 1 | Core voltage above lockout |
| ce_ni | input | 1 | Active-low chip select |
| oe_ni | input | 1 | Active-low output enable |
| we_ni | input | 1 | Active-low write strobe; rising edge latches a command cycle |
| addr_i | input | BLK_W+WOFF_W | Word address |
| data_i | input | DW | Write data / command byte |
| data_o | output | DW | Read data |
| data_oe_o | output | 1 | Read data valid; 0 stands for a released bus |
| ready_o | output | 1 | Ready (1) / busy (0) |

## Verification
The word-write path is driven with random addresses and data from a fixed seed. Repeated writes to the same word show whether the design ANDs new data into the old word or overwrites it. Directed sequences cover three kinds of condition. The first is blocked operations: locked block, low program voltage, low core voltage, and a supply drop during an operation. These separate the error bit that is set and show that the array stays untouched. The second is each suspend path, which shows whether a halted operation keeps its remaining time and its target. The third is power-down during a write, which shows abort versus completion.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID} rmode_e;
  typedef enum logic [1:0] {CS_IDLE, CS_WDATA, CS_ECONF, CS_LCONF} cstate_e;

  localparam logic [7:0] OP_RD_ARRAY = 8'hFF;
  localparam logic [7:0] OP_RD_ID    = 8'h90;
  localparam logic [7:0] OP_RD_SR    = 8'h70;
  localparam logic [7:0] OP_CLR_SR   = 8'h50;
  localparam logic [7:0] OP_WRITE    = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_LOCK_SET = 8'h01;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  input  logic run_i,
  output logic active_o,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (start_i)                cnt_q <= CW'(CYC);
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign done_o   = run_i && (cnt_q == CW'(1)) && !clr_i;

  // R3: a running, unsuspended operation loses exactly one cycle per clock
  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && run_i && !start_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DW     = 16,
  parameter int BLK_W  = 4,
  parameter int WOFF_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [BLK_W+WOFF_W-1:0] rd_addr_i,
  output logic [DW-1:0]           rd_data_o,
  input  logic                    wr_en_i,
  input  logic [BLK_W+WOFF_W-1:0] wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic                    ers_en_i,
  input  logic [BLK_W-1:0]        ers_blk_i,
  input  logic                    lk_en_i,
  input  logic [BLK_W-1:0]        lk_blk_i,
  input  logic                    lk_val_i,
  output logic [(1<<BLK_W)-1:0]   lock_o
);
  localparam int AW    = BLK_W + WOFF_W;
  localparam int NW    = 1 << AW;
  localparam int BWRDS = 1 << WOFF_W;
  localparam int NBLK  = 1 << BLK_W;

  logic [DW-1:0]   mem_q [NW];
  logic [NBLK-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) mem_q[i] <= '1;
    end else begin
      if (wr_en_i) mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
      if (ers_en_i)
        for (int i = 0; i < BWRDS; i++) mem_q[{ers_blk_i, WOFF_W'(i)}] <= '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= '0;
    else if (lk_en_i) lock_q[lk_blk_i] <= lk_val_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign lock_o    = lock_q;

  // R10: the engine commits at most one operation per cycle
  a_r10_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_i, ers_en_i, lk_en_i}));
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
  import flash_ctl_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          BLK_W     = 4,
  parameter int          WOFF_W    = 4,
  parameter int          WRITE_CYC = 6,
  parameter int          ERASE_CYC = 24,
  parameter int          LOCK_CYC  = 4,
  parameter logic [15:0] MFR_ID    = 16'h00A5,
  parameter logic [15:0] DEV_ID    = 16'h00C3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pwd_ni,
  input  logic                    vpp_ok_i,
  input  logic                    vcc_ok_i,
  input  logic                    ce_ni,
  input  logic                    oe_ni,
  input  logic                    we_ni,
  input  logic [BLK_W+WOFF_W-1:0] addr_i,
  input  logic [DW-1:0]           data_i,
  output logic [DW-1:0]           data_o,
  output logic                    data_oe_o,
  output logic                    ready_o
);
  localparam int AW   = BLK_W + WOFF_W;
  localparam int NBLK = 1 << BLK_W;

  logic we_q, stb;
  cstate_e cmd_q;
  rmode_e  rmode_q;
  logic ers_err_q, wr_err_q, vpp_err_q, lk_err_q, wr_susp_q, ers_susp_q;
  logic [AW-1:0]    wr_addr_q;
  logic [DW-1:0]    wr_data_q;
  logic [BLK_W-1:0] ers_blk_q, lk_blk_q;
  logic             lk_val_q;
  logic wr_act, wr_done, ers_act, ers_done, lk_act, lk_done;
  logic wr_start, ers_start, lk_start, wr_run, ers_run, busy;
  logic [NBLK-1:0]  lock_v;
  logic [DW-1:0]    arr_rd;
  logic [7:0]       op, sr;
  logic [BLK_W-1:0] blk_in;
  logic supply_ok, wr_ok, ers_ok, lk_cmd_ok;

  assign op        = data_i[7:0];
  assign blk_in    = addr_i[AW-1 -: BLK_W];
  assign supply_ok = vpp_ok_i && vcc_ok_i;
  assign stb       = pwd_ni && !ce_ni && we_ni && !we_q;

  assign wr_ok     = supply_ok && !lock_v[blk_in] && !(ers_act && blk_in == ers_blk_q);
  assign ers_ok    = supply_ok && !lock_v[blk_in];
  assign lk_cmd_ok = (op == OP_LOCK_SET) || (op == OP_CONFIRM);
  assign wr_start  = stb && cmd_q == CS_WDATA && wr_ok;
  assign ers_start = stb && cmd_q == CS_ECONF && op == OP_CONFIRM && ers_ok;
  assign lk_start  = stb && cmd_q == CS_LCONF && lk_cmd_ok && supply_ok;

  assign wr_run  = wr_act && !wr_susp_q;
  assign ers_run = ers_act && !ers_susp_q && !wr_act;
  assign busy    = wr_run || ers_run || lk_act;

  flash_op_timer #(.CYC(WRITE_CYC)) u_wr_tmr (.clk_i, .rst_ni, .clr_i(!pwd_ni),
    .start_i(wr_start), .run_i(!wr_susp_q), .active_o(wr_act), .done_o(wr_done));
  flash_op_timer #(.CYC(ERASE_CYC)) u_ers_tmr (.clk_i, .rst_ni, .clr_i(!pwd_ni),
    .start_i(ers_start), .run_i(!ers_susp_q && !wr_act), .active_o(ers_act), .done_o(ers_done));
  flash_op_timer #(.CYC(LOCK_CYC)) u_lk_tmr (.clk_i, .rst_ni, .clr_i(!pwd_ni),
    .start_i(lk_start), .run_i(1'b1), .active_o(lk_act), .done_o(lk_done));

  flash_array #(.DW(DW), .BLK_W(BLK_W), .WOFF_W(WOFF_W)) u_array (
    .clk_i, .rst_ni, .rd_addr_i(addr_i), .rd_data_o(arr_rd),
    .wr_en_i(wr_done && supply_ok), .wr_addr_i(wr_addr_q), .wr_data_i(wr_data_q),
    .ers_en_i(ers_done && supply_ok), .ers_blk_i(ers_blk_q),
    .lk_en_i(lk_done && supply_ok), .lk_blk_i(lk_blk_q), .lk_val_i(lk_val_q),
    .lock_o(lock_v));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CS_IDLE; rmode_q <= RM_ARRAY;
      {ers_err_q, wr_err_q, vpp_err_q, lk_err_q, wr_susp_q, ers_susp_q} <= '0;
      wr_addr_q <= '0; wr_data_q <= '0; ers_blk_q <= '0; lk_blk_q <= '0; lk_val_q <= 1'b0;
    end else if (!pwd_ni) begin
      cmd_q <= CS_IDLE; rmode_q <= RM_ARRAY;
      {ers_err_q, wr_err_q, vpp_err_q, lk_err_q, wr_susp_q, ers_susp_q} <= '0;
    end else begin
      // completion under a failed supply: no commit, flag error
      if (!supply_ok) begin
        if (wr_done || (lk_done && lk_val_q))   wr_err_q  <= 1'b1;
        if (ers_done || (lk_done && !lk_val_q)) ers_err_q <= 1'b1;
        if ((wr_done || ers_done || lk_done) && !vpp_ok_i) vpp_err_q <= 1'b1;
      end
      if (stb) begin
        unique case (cmd_q)
          CS_IDLE: begin
            unique case (op)
              OP_RD_ARRAY: rmode_q <= RM_ARRAY;
              OP_RD_ID:    rmode_q <= RM_ID;
              OP_RD_SR:    rmode_q <= RM_STATUS;
              OP_CLR_SR:   {ers_err_q, wr_err_q, vpp_err_q, lk_err_q} <= '0;
              OP_WRITE: if (!busy && !wr_act) begin
                cmd_q <= CS_WDATA; rmode_q <= RM_STATUS;
              end
              OP_ERASE: if (!busy && !wr_act && !ers_act) begin
                cmd_q <= CS_ECONF; rmode_q <= RM_STATUS;
              end
              OP_LOCK: if (!busy && !wr_act && !ers_act) begin
                cmd_q <= CS_LCONF; rmode_q <= RM_STATUS;
              end
              OP_SUSPEND: begin
                if (wr_run && !wr_done) begin
                  wr_susp_q <= 1'b1; rmode_q <= RM_STATUS;
                end else if (ers_run && !ers_done) begin
                  ers_susp_q <= 1'b1; rmode_q <= RM_STATUS;
                end
              end
              OP_CONFIRM: begin
                if (wr_susp_q) begin
                  wr_susp_q <= 1'b0; rmode_q <= RM_STATUS;
                end else if (ers_susp_q && !wr_act) begin
                  ers_susp_q <= 1'b0; rmode_q <= RM_STATUS;
                end
              end
              default: ;
            endcase
          end
          CS_WDATA: begin
            cmd_q <= CS_IDLE;
            if (wr_ok) begin
              wr_addr_q <= addr_i; wr_data_q <= data_i;
            end else begin
              wr_err_q <= 1'b1;
              if (!vpp_ok_i)      vpp_err_q <= 1'b1;
              if (lock_v[blk_in]) lk_err_q  <= 1'b1;
            end
          end
          CS_ECONF: begin
            cmd_q <= CS_IDLE;
            if (op != OP_CONFIRM) begin
              ers_err_q <= 1'b1; wr_err_q <= 1'b1;
            end else if (ers_ok) begin
              ers_blk_q <= blk_in;
            end else begin
              ers_err_q <= 1'b1;
              if (!vpp_ok_i)      vpp_err_q <= 1'b1;
              if (lock_v[blk_in]) lk_err_q  <= 1'b1;
            end
          end
          CS_LCONF: begin
            cmd_q <= CS_IDLE;
            if (!lk_cmd_ok) begin
              ers_err_q <= 1'b1; wr_err_q <= 1'b1;
            end else if (supply_ok) begin
              lk_blk_q <= blk_in; lk_val_q <= (op == OP_LOCK_SET);
            end else begin
              if (op == OP_LOCK_SET) wr_err_q <= 1'b1;
              else                   ers_err_q <= 1'b1;
              if (!vpp_ok_i) vpp_err_q <= 1'b1;
            end
          end
          default: cmd_q <= CS_IDLE;
        endcase
      end
    end
  end

  assign sr = {!busy, ers_susp_q, ers_err_q, wr_err_q, vpp_err_q, wr_susp_q, lk_err_q, 1'b0};

  logic [DW-1:0] id_word;
  always_comb begin
    unique case (addr_i[1:0])
      2'd0:    id_word = DW'(MFR_ID);
      2'd1:    id_word = DW'(DEV_ID);
      2'd2:    id_word = DW'(lock_v[blk_in]);
      default: id_word = '0;
    endcase
  end

  assign data_oe_o = pwd_ni && !ce_ni && !oe_ni;
  always_comb begin
    data_o = '0;
    if (data_oe_o) begin
      unique case (rmode_q)
        RM_STATUS: data_o = DW'(sr);
        RM_ID:     data_o = id_word;
        default:   data_o = arr_rd;
      endcase
    end
  end

  assign ready_o = !pwd_ni || !busy;

  a_r11_pd_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwd_ni |=> (!wr_act && !ers_act && !lk_act));
  a_r8_wsusp_holds_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_susp_q |-> wr_act);
  a_r9_esusp_holds_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_susp_q |-> ers_act);
  a_r10_one_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_run, ers_run, lk_act}));
  a_r9_erase_target_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ers_act && $past(ers_act) && pwd_ni) |-> $stable(ers_blk_q));
endmodule

// File: tb/flash_ctl_tb_top.sv
module flash_ctl_tb_top;
  localparam int BLK_W = 4, WOFF_W = 4, AW = 8, DW = 16, NW = 256, NB = 16;
  localparam int WCYC = 12, ECYC = 40, LCYC = 5;
  localparam logic [15:0] MFR = 16'h00A5, DEV = 16'h00C3;

  logic clk = 1'b0, rst_n = 1'b0, pwd_n = 1'b1, vpp_ok = 1'b1, vcc_ok = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rd_oe, ready;
  logic [15:0] mdl [NW];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_ctl #(.DW(DW), .BLK_W(BLK_W), .WOFF_W(WOFF_W), .WRITE_CYC(WCYC),
              .ERASE_CYC(ECYC), .LOCK_CYC(LCYC), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwd_ni(pwd_n), .vpp_ok_i(vpp_ok), .vcc_ok_i(vcc_ok),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr), .data_i(wdata),
    .data_o(rdata), .data_oe_o(rd_oe), .ready_o(ready));

  function automatic logic [AW-1:0] wa(int blk, int off);
    return AW'((blk << WOFF_W) | off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic br(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #2 d = rdata; rd_oe_seen = rd_oe;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask
  logic rd_oe_seen;

  task automatic wait_rdy();
    for (int n = 0; n < 1000; n++) begin
      if (ready) return;
      @(negedge clk);
    end
    chk("R10 ready timeout", 0, 1);
  endtask

  task automatic sr_is(string req, logic [7:0] exp);
    logic [DW-1:0] v;
    bw('0, 16'h0070); br('0, v); chk(req, v, {8'h00, exp});
  endtask

  task automatic arr_is(string req, logic [AW-1:0] a);
    logic [DW-1:0] v;
    bw('0, 16'h00FF); br(a, v); chk(req, v, mdl[a]);
  endtask

  task automatic ww(logic [AW-1:0] a, logic [DW-1:0] d);
    bw(a, 16'h0040); bw(a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int unsigned seed;
    int n;
    for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
    seed = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R10 ready after reset", ready, 1);
    chk("R1 bus released when deselected", rd_oe, 0);
    br(wa(4, 3), v); chk("R1 array mode after reset", v, 16'hFFFF);
    chk("R1 bus driven on read", rd_oe_seen, 1);
    sr_is("R7 status after reset", 8'h80);
    bw('0, 16'h0012); br('0, v); chk("R2 undefined opcode keeps mode", v, 16'h0080);

    // identifier readout
    bw('0, 16'h0090);
    br(wa(0, 0), v); chk("R1 id manufacturer", v, MFR);
    br(wa(0, 1), v); chk("R1 id device", v, DEV);
    br(wa(3, 2), v); chk("R1 id lock bit clear", v, 16'h0000);

    // bus release with output enable high
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #2 chk("R1 oe high releases bus", rd_oe, 0);
    ce_n = 1'b1;

    // word write timing
    ww(wa(1, 1), 16'h5A5A);
    n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk("R3 busy length", n, WCYC);
    mdl[wa(1, 1)] &= 16'h5A5A;
    arr_is("R3 word stored", wa(1, 1));

    // random word writes, some repeats to the same word
    for (int i = 0; i < 24; i++) begin
      a = (i % 4 == 3) ? wa(1, 1) : AW'($urandom % NW);
      d = DW'($urandom);
      ww(a, d);
      chk("R10 busy during write", ready, 0);
      wait_rdy();
      mdl[a] &= d;
      arr_is("R3 random write AND", a);
    end
    sr_is("R7 status clean after writes", 8'h80);

    // block erase
    ww(wa(2, 7), 16'h0F0F); wait_rdy(); mdl[wa(2, 7)] &= 16'h0F0F;
    ww(wa(3, 0), 16'h1234); wait_rdy(); mdl[wa(3, 0)] &= 16'h1234;
    bw(wa(2, 0), 16'h0020); bw(wa(2, 0), 16'h00D0);
    chk("R10 busy during erase", ready, 0);
    wait_rdy();
    for (int i = 0; i < 16; i++) mdl[wa(2, i)] = 16'hFFFF;
    for (int i = 0; i < 16; i++) arr_is("R4 block erased", wa(2, i));
    arr_is("R12 neighbour block intact", wa(3, 0));
    bw(wa(3, 0), 16'h0020); bw(wa(3, 0), 16'h0033);
    sr_is("R4 bad confirm error", 8'hB0);
    arr_is("R4 bad confirm no erase", wa(3, 0));
    bw('0, 16'h0050);
    sr_is("R7 clear status", 8'h80);

    // lock bits
    bw(wa(3, 0), 16'h0060); bw(wa(3, 0), 16'h0001); wait_rdy();
    bw('0, 16'h0090); br(wa(3, 2), v); chk("R5 lock bit set", v, 16'h0001);
    br(wa(4, 2), v); chk("R12 other block unlocked", v, 16'h0000);
    ww(wa(3, 0), 16'h0000);
    chk("R10 no busy on rejected write", ready, 1);
    sr_is("R5 locked write error", 8'h92);
    arr_is("R5 locked word unchanged", wa(3, 0));
    bw('0, 16'h0050);
    bw(wa(3, 0), 16'h0020); bw(wa(3, 0), 16'h00D0);
    sr_is("R5 locked erase error", 8'hA2);
    arr_is("R5 locked block not erased", wa(3, 0));
    bw('0, 16'h0050);
    bw(wa(3, 0), 16'h0060); bw(wa(3, 0), 16'h00D0); wait_rdy();
    bw('0, 16'h0090); br(wa(3, 2), v); chk("R5 lock bit cleared", v, 16'h0000);
    ww(wa(3, 0), 16'h0204); wait_rdy(); mdl[wa(3, 0)] &= 16'h0204;
    arr_is("R5 write after unlock", wa(3, 0));

    // supply lockout
    vpp_ok = 1'b0;
    ww(wa(7, 5), 16'h0000);
    sr_is("R6 vpp low error", 8'h98);
    arr_is("R6 vpp low no change", wa(7, 5));
    bw('0, 16'h0050); vpp_ok = 1'b1;
    vcc_ok = 1'b0;
    ww(wa(7, 5), 16'h0000);
    sr_is("R6 vcc low error", 8'h90);
    arr_is("R6 vcc low no change", wa(7, 5));
    bw('0, 16'h0050); vcc_ok = 1'b1;
    ww(wa(7, 6), 16'h0000);
    repeat (3) @(negedge clk);
    vpp_ok = 1'b0;
    wait_rdy();
    repeat (2) @(negedge clk);
    vpp_ok = 1'b1;
    sr_is("R6 vpp drop mid write", 8'h98);
    arr_is("R6 vpp drop no change", wa(7, 6));
    bw('0, 16'h0050);

    // write suspend / resume
    ww(wa(8, 3), 16'h00F0);
    bw('0, 16'h00B0);
    chk("R10 ready when write suspended", ready, 1);
    sr_is("R8 write suspended status", 8'h84);
    arr_is("R8 old data during suspend", wa(8, 3));
    bw('0, 16'h00D0);
    chk("R8 resume busy", ready, 0);
    wait_rdy(); mdl[wa(8, 3)] &= 16'h00F0;
    arr_is("R8 write completes after resume", wa(8, 3));

    // erase suspend: read, write other block, reject same block
    ww(wa(5, 9), 16'h3333); wait_rdy(); mdl[wa(5, 9)] &= 16'h3333;
    bw(wa(5, 0), 16'h0020); bw(wa(5, 0), 16'h00D0);
    repeat (4) @(negedge clk);
    bw('0, 16'h00B0);
    chk("R10 ready when erase suspended", ready, 1);
    sr_is("R9 erase suspended status", 8'hC0);
    arr_is("R9 read during erase suspend", wa(5, 9));
    ww(wa(6, 4), 16'h7E7E);
    chk("R9 write runs during erase suspend", ready, 0);
    wait_rdy(); mdl[wa(6, 4)] &= 16'h7E7E;
    sr_is("R9 erase still suspended", 8'hC0);
    arr_is("R9 other-block write stored", wa(6, 4));
    ww(wa(5, 9), 16'h0000);
    sr_is("R9 write to suspended block rejected", 8'hD0);
    bw('0, 16'h0050);
    bw('0, 16'h00D0);
    chk("R9 erase resumes busy", ready, 0);
    wait_rdy();
    for (int i = 0; i < 16; i++) mdl[wa(5, i)] = 16'hFFFF;
    arr_is("R9 erase completes", wa(5, 9));
    arr_is("R9 erase completes other word", wa(5, 0));
    sr_is("R7 idle after erase", 8'h80);

    // power-down
    ww(wa(9, 2), 16'h0000);
    @(negedge clk); pwd_n = 1'b0;
    @(negedge clk);
    chk("R10 ready in power-down", ready, 1);
    ce_n = 1'b0; oe_n = 1'b0; #2 chk("R11 bus off in power-down", rd_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    ww(wa(9, 3), 16'h0000);
    repeat (WCYC + 2) @(negedge clk);
    pwd_n = 1'b1;
    @(negedge clk);
    br(wa(9, 2), v); chk("R11 aborted write, array mode", v, mdl[wa(9, 2)]);
    br(wa(9, 3), v); chk("R11 write ignored in power-down", v, mdl[wa(9, 3)]);
    sr_is("R11 status clean after power-down", 8'h80);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule